// File: doc/BRIEF.md
# Posted Write Buffer for a Window-Timed Slow Bus

This block sits between a fast processor and a slow system bus. The bus accepts a transfer only at the start of a periodic access window, 500 ns long. A bus-window strobe, one fast-clock cycle wide, marks the start of each window. When the processor writes to the slow bus, the block stores the address and data in a small FIFO and acknowledges in the same cycle. The processor then continues running, and the stored writes go out one per window in the background.

Reads cannot be posted. A read is held until every earlier buffered write has reached the bus, so the bus sees accesses in program order. The read then takes the next window. Its data comes back to the processor with a single-cycle valid pulse, and the handshake completes in that same cycle. The block also exports an empty flag, so that mode-change logic can wait until all posted writes have drained.

Top module: `pwb_top`

## Requirements
- R1: A processor write (`cpuReq` and `cpuWrite` high) is accepted in the same cycle, with `cpuReady` high, whenever the buffer holds fewer than DEPTH entries.
- R2: When DEPTH writes are pending, `cpuReady` stays low for a write request, and no write is lost or overwritten. The write is accepted in the first cycle in which space has freed up.
- R3: A read goes onto the bus only after the buffer is empty. The data it returns reflects every write that was accepted before it.
- R4: `busWe` and `busRe` are each high for exactly one cycle, and only in the cycle right after a `winStart` strobe.
- R5: At most one transfer is made per window. Buffered writes leave in the order in which they were accepted, carrying their own address and data.
- R6: The read data is presented on `cpuRdata` with `cpuRvalid` high for one cycle, two cycles after the window strobe that started the read. `cpuReady` is high for the read in that same cycle.
- R7: `bufEmpty` is high exactly when no accepted write is still waiting for the bus.
- R8: While `rstN` is low, `cpuReady` (for a read request), `busWe`, `busRe` and `cpuRvalid` are low, and `bufEmpty` is high.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Fast processor clock |
| rstN | input | 1 | Active-low synchronous reset |
| cpuReq | input | 1 | Processor request valid |
| cpuWrite | input | 1 | 1 = write, 0 = read |
| cpuAddr | input | AW | Processor address |
| cpuWdata | input | DW | Processor write data |
| cpuReady | output | 1 | Request accepted / completed this cycle |
| cpuRdata | output | DW | Read data returned |
| cpuRvalid | output | 1 | One-cycle pulse marking valid read data |
| winStart | input | 1 | One-cycle strobe at the start of a bus window |
| busAddr | output | AW | Bus address |
| busWdata | output | DW | Bus write data |
| busWe | output | 1 | Bus write strobe |
| busRe | output | 1 | Bus read strobe |
| busRdata | input | DW | Bus read data, valid while `busRe` is high |
| bufEmpty | output | 1 | No posted write is pending |

## Verification
The assertions rely on three assumptions about the inputs:
- `winStart` pulses are at least three cycles apart, so that a read can complete before the next window opens.
- The processor holds its request steady until it sees `cpuReady`.
- `busRdata` is valid during the cycle in which `busRe` is high.

The stimulus stays within these limits. It drives a window strobe every eight cycles and changes the request only after an accepted handshake. It returns bus read data combinationally from a small memory model.

// File: rtl/pwb_pkg.sv
package pwb_pkg;
  typedef struct packed {
    logic push;
    logic pop;
    logic issueRead;
    logic capture;
  } pwbCtl_t;

  typedef enum logic [1:0] {RD_IDLE, RD_BUS, RD_DONE} rdState_t;
endpackage

// File: rtl/pwb_datapath.sv
module pwb_datapath import pwb_pkg::*; #(
  parameter int AW    = 16,
  parameter int DW    = 8,
  parameter int DEPTH = 4,
  localparam int PW   = (DEPTH > 1) ? $clog2(DEPTH) : 1,
  localparam int CW   = $clog2(DEPTH + 1)
) (
  input  logic          clk,
  input  logic          rstN,
  input  pwbCtl_t       ctl,
  input  logic [AW-1:0] cpuAddr,
  input  logic [DW-1:0] cpuWdata,
  input  logic [DW-1:0] busRdata,
  output logic [AW-1:0] busAddr,
  output logic [DW-1:0] busWdata,
  output logic          busWe,
  output logic          busRe,
  output logic [DW-1:0] cpuRdata,
  output logic          cpuRvalid,
  output logic [CW-1:0] fillLevel
);
  logic [AW+DW-1:0] slots [DEPTH];
  logic [PW-1:0]    wrPtr, rdPtr;
  logic [AW+DW-1:0] headEntry;

  assign headEntry = slots[rdPtr];

  // One storage register per slot, loaded when the write pointer selects it.
  for (genvar g = 0; g < DEPTH; g++) begin : gSlot
    always_ff @(posedge clk) begin
      if (ctl.push && wrPtr == PW'(g)) slots[g] <= {cpuAddr, cpuWdata};
    end
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      wrPtr     <= '0;
      rdPtr     <= '0;
      fillLevel <= '0;
    end else begin
      if (ctl.push) wrPtr <= (wrPtr == PW'(DEPTH - 1)) ? '0 : wrPtr + 1'b1;
      if (ctl.pop)  rdPtr <= (rdPtr == PW'(DEPTH - 1)) ? '0 : rdPtr + 1'b1;
      case ({ctl.push, ctl.pop})
        2'b10:   fillLevel <= fillLevel + 1'b1;
        2'b01:   fillLevel <= fillLevel - 1'b1;
        default: fillLevel <= fillLevel;
      endcase
    end
  end

  // Bus-side and return registers.
  always_ff @(posedge clk) begin
    if (!rstN) begin
      busAddr   <= '0;
      busWdata  <= '0;
      busWe     <= 1'b0;
      busRe     <= 1'b0;
      cpuRdata  <= '0;
      cpuRvalid <= 1'b0;
    end else begin
      busWe     <= ctl.pop;
      busRe     <= ctl.issueRead;
      cpuRvalid <= ctl.capture;
      if (ctl.pop) begin
        busAddr  <= headEntry[AW+DW-1:DW];
        busWdata <= headEntry[DW-1:0];
      end else if (ctl.issueRead) begin
        busAddr <= cpuAddr;
      end
      if (ctl.capture) cpuRdata <= busRdata;
    end
  end
endmodule

// File: rtl/pwb_control.sv
module pwb_control import pwb_pkg::*; #(
  parameter int DEPTH = 4,
  localparam int CW   = $clog2(DEPTH + 1)
) (
  input  logic          clk,
  input  logic          rstN,
  input  logic          cpuReq,
  input  logic          cpuWrite,
  input  logic          winStart,
  input  logic [CW-1:0] fillLevel,
  output logic          cpuReady,
  output logic          bufEmpty,
  output pwbCtl_t       ctl
);
  rdState_t rdState;
  logic     bufFull;

  assign bufEmpty = (fillLevel == '0);
  assign bufFull  = (fillLevel == CW'(DEPTH));

  always_comb begin
    ctl.push      = cpuReq && cpuWrite && !bufFull;
    ctl.pop       = winStart && !bufEmpty;
    ctl.issueRead = winStart && bufEmpty && (rdState == RD_IDLE) && cpuReq && !cpuWrite;
    ctl.capture   = (rdState == RD_BUS);
    cpuReady      = cpuWrite ? !bufFull : (rdState == RD_DONE);
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      rdState <= RD_IDLE;
    end else begin
      unique case (rdState)
        RD_IDLE: if (ctl.issueRead) rdState <= RD_BUS;
        RD_BUS:  rdState <= RD_DONE;
        RD_DONE: rdState <= RD_IDLE;
        default: rdState <= RD_IDLE;
      endcase
    end
  end
endmodule

// File: rtl/pwb_top.sv
module pwb_top import pwb_pkg::*; #(
  parameter int AW    = 16,
  parameter int DW    = 8,
  parameter int DEPTH = 4
) (
  input  logic          clk,
  input  logic          rstN,
  input  logic          cpuReq,
  input  logic          cpuWrite,
  input  logic [AW-1:0] cpuAddr,
  input  logic [DW-1:0] cpuWdata,
  output logic          cpuReady,
  output logic [DW-1:0] cpuRdata,
  output logic          cpuRvalid,
  input  logic          winStart,
  output logic [AW-1:0] busAddr,
  output logic [DW-1:0] busWdata,
  output logic          busWe,
  output logic          busRe,
  input  logic [DW-1:0] busRdata,
  output logic          bufEmpty
);
  localparam int CW = $clog2(DEPTH + 1);

  pwbCtl_t       ctl;
  logic [CW-1:0] fillLevel;

  pwb_control #(.DEPTH(DEPTH)) uCtl (
    .clk(clk), .rstN(rstN), .cpuReq(cpuReq), .cpuWrite(cpuWrite),
    .winStart(winStart), .fillLevel(fillLevel), .cpuReady(cpuReady),
    .bufEmpty(bufEmpty), .ctl(ctl)
  );

  pwb_datapath #(.AW(AW), .DW(DW), .DEPTH(DEPTH)) uDp (
    .clk(clk), .rstN(rstN), .ctl(ctl), .cpuAddr(cpuAddr), .cpuWdata(cpuWdata),
    .busRdata(busRdata), .busAddr(busAddr), .busWdata(busWdata), .busWe(busWe),
    .busRe(busRe), .cpuRdata(cpuRdata), .cpuRvalid(cpuRvalid), .fillLevel(fillLevel)
  );
endmodule

// File: rtl/pwb_checker.sv
module pwb_checker #(
  parameter int DEPTH = 4,
  localparam int CW   = $clog2(DEPTH + 1)
) (
  input logic          clk,
  input logic          rstN,
  input logic          cpuReq,
  input logic          cpuWrite,
  input logic          cpuReady,
  input logic          winStart,
  input logic          busWe,
  input logic          busRe,
  input logic          cpuRvalid,
  input logic          bufEmpty,
  input logic [CW-1:0] fillLevel
);
  a_r4_write_on_window: assert property (@(posedge clk) disable iff (!rstN)
    busWe |-> $past(winStart));
  a_r4_read_on_window: assert property (@(posedge clk) disable iff (!rstN)
    busRe |-> $past(winStart));
  a_r5_one_transfer: assert property (@(posedge clk) disable iff (!rstN)
    !(busWe && busRe));
  a_r3_read_after_drain: assert property (@(posedge clk) disable iff (!rstN)
    busRe |-> $past(bufEmpty));
  a_r6_rvalid_single: assert property (@(posedge clk) disable iff (!rstN)
    cpuRvalid |=> !cpuRvalid);
  a_r6_rvalid_after_read: assert property (@(posedge clk) disable iff (!rstN)
    cpuRvalid |-> $past(busRe));
  a_r2_no_overflow: assert property (@(posedge clk) disable iff (!rstN)
    fillLevel <= CW'(DEPTH));
  a_r2_full_stalls: assert property (@(posedge clk) disable iff (!rstN)
    (cpuReq && cpuWrite && fillLevel == CW'(DEPTH)) |-> !cpuReady);
  a_r7_write_needs_entry: assert property (@(posedge clk) disable iff (!rstN)
    busWe |-> !$past(bufEmpty));
endmodule

bind pwb_top pwb_checker #(.DEPTH(DEPTH)) uChk (
  .clk(clk), .rstN(rstN), .cpuReq(cpuReq), .cpuWrite(cpuWrite),
  .cpuReady(cpuReady), .winStart(winStart), .busWe(busWe), .busRe(busRe),
  .cpuRvalid(cpuRvalid), .bufEmpty(bufEmpty), .fillLevel(fillLevel)
);

// File: tb/pwb_top_test.sv
`timescale 1ns/100ps
module pwb_top_test;
  localparam int AW = 16, DW = 8, DEPTH = 4, WIN = 8;

  logic clk = 1'b0, rstN = 1'b0;
  always #2.5 clk = ~clk;

  logic          cpuReq = 0, cpuWrite = 0, winStart = 0;
  logic [AW-1:0] cpuAddr = '0;
  logic [DW-1:0] cpuWdata = '0;
  logic          cpuReady, cpuRvalid, busWe, busRe, bufEmpty;
  logic [DW-1:0] cpuRdata, busWdata, busRdata;
  logic [AW-1:0] busAddr;

  pwb_top #(.AW(AW), .DW(DW), .DEPTH(DEPTH)) uut (
    .clk(clk), .rstN(rstN), .cpuReq(cpuReq), .cpuWrite(cpuWrite), .cpuAddr(cpuAddr),
    .cpuWdata(cpuWdata), .cpuReady(cpuReady), .cpuRdata(cpuRdata), .cpuRvalid(cpuRvalid),
    .winStart(winStart), .busAddr(busAddr), .busWdata(busWdata), .busWe(busWe),
    .busRe(busRe), .busRdata(busRdata), .bufEmpty(bufEmpty)
  );

  int vectors = 0, fails = 0;

  // Slow-bus memory.
  logic [DW-1:0] busMem [16];
  initial for (int i = 0; i < 16; i++) busMem[i] = '0;
  assign busRdata = busMem[busAddr[3:0]];
  always @(posedge clk) if (busWe) busMem[busAddr[3:0]] <= busWdata;

  // Window strobe every WIN cycles.
  int winCnt = 0;
  logic winSeen = 0;
  always @(negedge clk) begin
    if (!rstN) begin winCnt = 0; winStart = 0; end
    else begin
      winStart = (winCnt == WIN - 1);
      winCnt   = (winCnt == WIN - 1) ? 0 : winCnt + 1;
    end
  end
  always @(posedge clk) winSeen <= winStart;

  // Behavioural reference model.
  logic [AW+DW-1:0] q[$];
  logic [DW-1:0] mMem [16];
  int rd, sz;
  bit doPush;
  logic mWe, mRe, mRv;
  logic [AW-1:0] mAddr;
  logic [DW-1:0] mWd, mRd;
  initial for (int i = 0; i < 16; i++) mMem[i] = '0;

  always @(posedge clk) begin
    if (!rstN) begin
      q.delete(); rd = 0; mWe = 0; mRe = 0; mRv = 0; mAddr = '0; mWd = '0; mRd = '0;
    end else begin
      sz = q.size();
      doPush = cpuReq && cpuWrite && (sz < DEPTH);
      mRv = 0;
      if (rd == 1) begin mRv = 1; mRd = mMem[mAddr[3:0]]; rd = 2; end
      else if (rd == 2) rd = 0;
      mWe = 0; mRe = 0;
      if (winStart && sz > 0) begin
        {mAddr, mWd} = q.pop_front();
        mWe = 1;
        mMem[mAddr[3:0]] = mWd;
      end else if (winStart && rd == 0 && cpuReq && !cpuWrite) begin
        mRe = 1; mAddr = cpuAddr; rd = 1;
      end
      if (doPush) q.push_back({cpuAddr, cpuWdata});
    end
  end

  task automatic chk(string tag, logic [31:0] act, logic [31:0] exp);
    vectors++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s actual=%0h expected=%0h at %0t", tag, act, exp, $time);
    end
  endtask

  always @(negedge clk) begin
    #1;
    if (rstN) begin
      if (cpuWrite) chk(q.size() >= DEPTH ? "R2 cpuReady full" : "R1 cpuReady write",
                        32'(cpuReady), 32'(q.size() < DEPTH));
      else chk("R6 cpuReady read", 32'(cpuReady), 32'(rd == 2));
      chk("R5 busWe", 32'(busWe), 32'(mWe));
      chk("R5 busAddr", 32'(busAddr), 32'(mAddr));
      chk("R5 busWdata", 32'(busWdata), 32'(mWd));
      chk("R3 busRe", 32'(busRe), 32'(mRe));
      chk("R6 cpuRvalid", 32'(cpuRvalid), 32'(mRv));
      if (mRv) chk("R3 cpuRdata", 32'(cpuRdata), 32'(mRd));
      chk("R7 bufEmpty", 32'(bufEmpty), 32'(q.size() == 0));
      chk("R4 window alignment", 32'((busWe || busRe) && !winSeen), 32'd0);
    end
  end

  task automatic doWrite(input logic [3:0] a, input logic [DW-1:0] d);
    bit acc;
    @(negedge clk);
    cpuReq = 1; cpuWrite = 1; cpuAddr = {12'h0, a}; cpuWdata = d;
    while (1) begin
      #1; acc = cpuReady;
      @(posedge clk);
      if (acc) break;
      @(negedge clk);
    end
  endtask

  task automatic doRead(input logic [3:0] a);
    bit acc;
    @(negedge clk);
    cpuReq = 1; cpuWrite = 0; cpuAddr = {12'h0, a};
    while (1) begin
      #1; acc = cpuReady;
      @(posedge clk);
      if (acc) break;
      @(negedge clk);
    end
  endtask

  task automatic idle(input int n);
    @(negedge clk);
    cpuReq = 0; cpuWrite = 0;
    repeat (n) @(negedge clk);
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    fails++;
    $display("FAIL watchdog expired actual=running expected=done");
    $display("  == %0d vectors applied, %0d miscompares ==", vectors, fails);
    $finish;
  end

  initial begin
    // R8: reset state, with a read request pending.
    cpuReq = 1; cpuWrite = 0;
    repeat (4) @(negedge clk);
    #1;
    chk("R8 cpuReady", 32'(cpuReady), 0);
    chk("R8 busWe", 32'(busWe), 0);
    chk("R8 busRe", 32'(busRe), 0);
    chk("R8 cpuRvalid", 32'(cpuRvalid), 0);
    chk("R8 bufEmpty", 32'(bufEmpty), 1);
    cpuReq = 0;
    @(negedge clk); rstN = 1;

    // R1/R3: four posted writes, then a read of the last address.
    for (int i = 0; i < 4; i++) doWrite(4'(i), 8'(8'h10 + i));
    doRead(4'd3);
    idle(3);
    // R2/R5: burst beyond the depth forces a stall, then in-order drain.
    for (int i = 0; i < 7; i++) doWrite(4'(i + 4), 8'(8'hA0 + i));
    doRead(4'd5);
    doRead(4'd10);
    idle(20);
    // Mixed traffic.
    for (int k = 0; k < 400; k++) begin
      case ($urandom % 4)
        0, 1: doWrite(4'($urandom), 8'($urandom));
        2:    doRead(4'($urandom));
        default: idle($urandom % 10);
      endcase
    end
    idle(60);
    $display("  == %0d vectors applied, %0d miscompares ==", vectors, fails);
    $finish;
  end
endmodule